// File: doc/BRIEF.md
# Interleaving Flash Command Agent

This block schedules physical flash commands (read, program, erase) for one flash module. The module's four 8-bit buses carry chips that are grouped into four super chips of four chips each. An operation on one super chip does not hold back the other three. The agent takes commands from an input handshake and keeps them in a small pending window. It issues each command to its super chip as soon as that super chip has nothing outstanding, even when older commands are still blocked behind a long operation on a different super chip. A long erase therefore overlaps with reads and programs on the other super chips.

The agent learns that an issued operation has finished only by polling. It sends a status check to a super chip that has an operation outstanding, and on the next cycle it reads back whether that super chip is still busy. When the super chip is idle, the command is retired and a completion reports its tag and super chip. Inside the block, the flash side is modelled by one countdown per super chip. Each countdown stays busy for a fixed number of cycles that depends on the operation.

The scheduler is a two-state machine. In `AG_PICK` it issues the oldest pending command whose super chip is free and stays in `AG_PICK`. If no such command exists but some super chip is outstanding, it polls one of them and takes the transition PICK-to-STATUS. In `AG_STATUS` it reads the polled status, retires the command if the super chip is idle, and always takes the transition STATUS-to-PICK.

Top module: `ica_agent`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no command is issued, no poll is sent, no completion is reported, and the agent is ready for input.
- R2: The pending window holds up to DEPTH commands. `cmd_ready` is high exactly when fewer than DEPTH commands are pending (accepted but not yet issued).
- R3: A command issued in a cycle is the oldest pending command whose super chip has no outstanding operation. Its op, super chip, tag and address are unchanged. As a result, a command to a free super chip overtakes an older command that is blocked on a busy one.
- R4: Commands to the same super chip are issued and completed in arrival order.
- R5: Each super chip has at most one outstanding operation. No command is issued to a super chip until the completion of its previous operation has been reported.
- R6: A status poll targets only a super chip with an outstanding operation. The polled super chip is chosen round-robin: it is the first outstanding super chip at or after the one following the previous poll, starting from super chip 0 after reset.
- R7: The op encoding is 0 read, 1 program, 2 erase. These ops keep the super chip busy for LAT_RD, LAT_PG and LAT_ER cycles respectively. A completion appears in the cycle after the poll of that super chip, and only when the operation has finished, which is at least latency+1 cycles after the issue cycle. The completion carries the tag and super chip of the retired command.
- R8: Every accepted command produces exactly one completion.
- R9: Issue has priority over polling. A poll is sent only in a cycle in which no pending command targets a free super chip, and issue, poll and completion never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Window has room; command accepted when valid and ready |
| cmd_op | input | 2 | Operation: 0 read, 1 program, 2 erase |
| cmd_sc | input | 2 | Target super chip |
| cmd_tag | input | TAG_W | Command tag, returned on completion |
| cmd_addr | input | ADDR_W | Super block and page address within the super chip |
| fl_issue_valid | output | 1 | Command issued to the flash controllers this cycle |
| fl_issue_op | output | 2 | Issued operation |
| fl_issue_sc | output | 2 | Issued super chip |
| fl_issue_tag | output | TAG_W | Issued tag |
| fl_issue_addr | output | ADDR_W | Issued address |
| fl_poll_valid | output | 1 | Status check sent this cycle |
| fl_poll_sc | output | 2 | Super chip being polled |
| done_valid | output | 1 | Command retired this cycle |
| done_tag | output | TAG_W | Tag of the retired command |
| done_sc | output | 2 | Super chip the retired command ran on |

## Verification
The bench builds the agent with four super chips, an eight-entry window, 8-bit tags and short latencies (4, 10 and 30 cycles). With these latencies an erase sits outstanding long enough that several reads and programs to other super chips are issued past it, and the window fills within a few hundred cycles. Random traffic with a fixed seed then mixes ops and super chips so that blocked heads, round-robin polls over partially busy sets, and completions that coincide with new arrivals all occur many times. Directed sequences pin down the overtaking order and a completely full window.

// File: rtl/ica_pkg.sv
package ica_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } flash_op_e;

    typedef enum logic {
        AG_PICK   = 1'b0,
        AG_STATUS = 1'b1
    } ag_state_e;

endpackage

// File: rtl/ica_window.sv
module ica_window #(
    parameter int DEPTH  = 8,
    parameter int SC_N   = 4,
    parameter int TAG_W  = 8,
    parameter int ADDR_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  ica_pkg::flash_op_e      push_op,
    input  logic [$clog2(SC_N)-1:0] push_sc,
    input  logic [TAG_W-1:0]        push_tag,
    input  logic [ADDR_W-1:0]       push_addr,
    output logic                    full,
    input  logic [SC_N-1:0]         sc_blocked,
    input  logic                    pop,
    output logic                    pick_valid,
    output ica_pkg::flash_op_e      pick_op,
    output logic [$clog2(SC_N)-1:0] pick_sc,
    output logic [TAG_W-1:0]        pick_tag,
    output logic [ADDR_W-1:0]       pick_addr
);
    localparam int SC_W  = $clog2(SC_N);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    ica_pkg::flash_op_e e_op   [DEPTH];
    logic [SC_W-1:0]    e_sc   [DEPTH];
    logic [TAG_W-1:0]   e_tag  [DEPTH];
    logic [ADDR_W-1:0]  e_addr [DEPTH];
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   pick_idx;
    logic [IDX_W-1:0]   wr_idx;

    // oldest entry (lowest index) whose super chip is free
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (CNT_W'(i) < cnt && !sc_blocked[e_sc[i]]) begin
                pick_valid = 1'b1;
                pick_idx   = IDX_W'(i);
            end
        end
    end

    assign pick_op   = e_op[pick_idx];
    assign pick_sc   = e_sc[pick_idx];
    assign pick_tag  = e_tag[pick_idx];
    assign pick_addr = e_addr[pick_idx];
    assign full      = (cnt == CNT_W'(DEPTH));
    assign wr_idx    = IDX_W'(pop ? cnt - CNT_W'(1) : cnt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                e_op[i]   <= ica_pkg::OP_READ;
                e_sc[i]   <= '0;
                e_tag[i]  <= '0;
                e_addr[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (pop && i >= int'(pick_idx)) begin
                    e_op[i]   <= e_op[i+1];
                    e_sc[i]   <= e_sc[i+1];
                    e_tag[i]  <= e_tag[i+1];
                    e_addr[i] <= e_addr[i+1];
                end
            end
            if (push) begin
                e_op[wr_idx]   <= push_op;
                e_sc[wr_idx]   <= push_sc;
                e_tag[wr_idx]  <= push_tag;
                e_addr[wr_idx] <= push_addr;
            end
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < CNT_W'(DEPTH) || pop));

    // R3
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0 && pick_valid));

endmodule

// File: rtl/ica_sc_timer.sv
module ica_sc_timer #(
    parameter int LAT_RD = 8,
    parameter int LAT_PG = 24,
    parameter int LAT_ER = 96
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  ica_pkg::flash_op_e op,
    output logic               busy
);
    localparam int MAX_A = (LAT_RD > LAT_PG) ? LAT_RD : LAT_PG;
    localparam int MAX_L = (MAX_A > LAT_ER) ? MAX_A : LAT_ER;
    localparam int CW    = $clog2(MAX_L + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load;

    always_comb begin
        unique case (op)
            ica_pkg::OP_PROG:  load = CW'(LAT_PG);
            ica_pkg::OP_ERASE: load = CW'(LAT_ER);
            default:           load = CW'(LAT_RD);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= load;
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/ica_rr_pick.sv
module ica_rr_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    input  logic [$clog2(N)-1:0] ptr,
    output logic                 gnt_valid,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int W = $clog2(N);

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 0; k < N; k++) begin
            automatic int idx = (int'(ptr) + k) % N;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_idx   = W'(idx);
            end
        end
    end

    // R6
    always_comb begin
        if (gnt_valid) begin
            grant_has_req_chk: assert (req[gnt_idx]);
        end
    end

endmodule

// File: rtl/ica_agent.sv
module ica_agent #(
    parameter int SC_N   = 4,
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 8,
    parameter int ADDR_W = 24,
    parameter int LAT_RD = 8,
    parameter int LAT_PG = 24,
    parameter int LAT_ER = 96
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [1:0]              cmd_op,
    input  logic [$clog2(SC_N)-1:0] cmd_sc,
    input  logic [TAG_W-1:0]        cmd_tag,
    input  logic [ADDR_W-1:0]       cmd_addr,
    output logic                    fl_issue_valid,
    output logic [1:0]              fl_issue_op,
    output logic [$clog2(SC_N)-1:0] fl_issue_sc,
    output logic [TAG_W-1:0]        fl_issue_tag,
    output logic [ADDR_W-1:0]       fl_issue_addr,
    output logic                    fl_poll_valid,
    output logic [$clog2(SC_N)-1:0] fl_poll_sc,
    output logic                    done_valid,
    output logic [TAG_W-1:0]        done_tag,
    output logic [$clog2(SC_N)-1:0] done_sc
);
    import ica_pkg::*;

    localparam int SC_W = $clog2(SC_N);

    ag_state_e         state, state_nx;
    logic [SC_N-1:0]   outst;
    logic [TAG_W-1:0]  out_tag [SC_N];
    logic [SC_W-1:0]   rr_ptr;
    logic [SC_W-1:0]   poll_sc_q;
    logic [SC_N-1:0]   sc_busy;

    logic              win_full;
    logic              pick_valid;
    flash_op_e         pick_op;
    logic [SC_W-1:0]   pick_sc;
    logic [TAG_W-1:0]  pick_tag;
    logic [ADDR_W-1:0] pick_addr;
    logic              gnt_valid;
    logic [SC_W-1:0]   gnt_idx;
    logic              push;

    assign cmd_ready = !win_full;
    assign push      = cmd_valid && cmd_ready;

    ica_window #(
        .DEPTH (DEPTH),
        .SC_N  (SC_N),
        .TAG_W (TAG_W),
        .ADDR_W(ADDR_W)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_op   (flash_op_e'(cmd_op)),
        .push_sc   (cmd_sc),
        .push_tag  (cmd_tag),
        .push_addr (cmd_addr),
        .full      (win_full),
        .sc_blocked(outst),
        .pop       (fl_issue_valid),
        .pick_valid(pick_valid),
        .pick_op   (pick_op),
        .pick_sc   (pick_sc),
        .pick_tag  (pick_tag),
        .pick_addr (pick_addr)
    );

    ica_rr_pick #(.N(SC_N)) u_rr (
        .req      (outst),
        .ptr      (rr_ptr),
        .gnt_valid(gnt_valid),
        .gnt_idx  (gnt_idx)
    );

    for (genvar g = 0; g < SC_N; g++) begin : g_sc
        ica_sc_timer #(
            .LAT_RD(LAT_RD),
            .LAT_PG(LAT_PG),
            .LAT_ER(LAT_ER)
        ) u_timer (
            .clk  (clk),
            .rst_n(rst_n),
            .start(fl_issue_valid && fl_issue_sc == SC_W'(g)),
            .op   (pick_op),
            .busy (sc_busy[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= AG_PICK;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            AG_PICK:   if (!pick_valid && gnt_valid) state_nx = AG_STATUS;
            AG_STATUS: state_nx = AG_PICK;
            default:   state_nx = AG_PICK;
        endcase
    end

    // outputs
    always_comb begin
        fl_issue_valid = 1'b0;
        fl_poll_valid  = 1'b0;
        done_valid     = 1'b0;
        unique case (state)
            AG_PICK: begin
                fl_issue_valid = pick_valid;
                fl_poll_valid  = !pick_valid && gnt_valid;
            end
            AG_STATUS: done_valid = !sc_busy[poll_sc_q];
            default: ;
        endcase
    end

    assign fl_issue_op   = pick_op;
    assign fl_issue_sc   = pick_sc;
    assign fl_issue_tag  = pick_tag;
    assign fl_issue_addr = pick_addr;
    assign fl_poll_sc    = gnt_idx;
    assign done_sc       = poll_sc_q;
    assign done_tag      = out_tag[poll_sc_q];

    // outstanding bookkeeping and poll pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst     <= '0;
            rr_ptr    <= '0;
            poll_sc_q <= '0;
            for (int i = 0; i < SC_N; i++) out_tag[i] <= '0;
        end else begin
            if (fl_issue_valid) begin
                outst[fl_issue_sc]   <= 1'b1;
                out_tag[fl_issue_sc] <= fl_issue_tag;
            end
            if (done_valid) outst[done_sc] <= 1'b0;
            if (fl_poll_valid) begin
                poll_sc_q <= gnt_idx;
                rr_ptr    <= (gnt_idx == SC_W'(SC_N - 1)) ? '0 : gnt_idx + SC_W'(1);
            end
        end
    end

    // R5
    issue_free_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_issue_valid |-> !outst[fl_issue_sc]);

    // R6
    poll_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_poll_valid |-> outst[fl_poll_sc]);

    // R7
    done_after_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> ($past(fl_poll_valid) && $past(fl_poll_sc) == done_sc && outst[done_sc]));

    // R9
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fl_issue_valid, fl_poll_valid, done_valid}) <= 1);

endmodule

// File: tb/tb_ica_agent.sv
module tb_ica_agent;
    localparam int SC_N   = 4;
    localparam int DEPTH  = 8;
    localparam int TAG_W  = 8;
    localparam int ADDR_W = 24;
    localparam int L_RD   = 4;
    localparam int L_PG   = 10;
    localparam int L_ER   = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [1:0]        cmd_op = '0;
    logic [1:0]        cmd_sc = '0;
    logic [TAG_W-1:0]  cmd_tag = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              fl_issue_valid;
    logic [1:0]        fl_issue_op;
    logic [1:0]        fl_issue_sc;
    logic [TAG_W-1:0]  fl_issue_tag;
    logic [ADDR_W-1:0] fl_issue_addr;
    logic              fl_poll_valid;
    logic [1:0]        fl_poll_sc;
    logic              done_valid;
    logic [TAG_W-1:0]  done_tag;
    logic [1:0]        done_sc;

    always #5 clk = ~clk;

    ica_agent #(
        .SC_N(SC_N), .DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
        .LAT_RD(L_RD), .LAT_PG(L_PG), .LAT_ER(L_ER)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_sc(cmd_sc), .cmd_tag(cmd_tag), .cmd_addr(cmd_addr),
        .fl_issue_valid(fl_issue_valid), .fl_issue_op(fl_issue_op),
        .fl_issue_sc(fl_issue_sc), .fl_issue_tag(fl_issue_tag),
        .fl_issue_addr(fl_issue_addr), .fl_poll_valid(fl_poll_valid),
        .fl_poll_sc(fl_poll_sc), .done_valid(done_valid),
        .done_tag(done_tag), .done_sc(done_sc)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // reference model state
    int q_op [DEPTH];
    int q_sc [DEPTH];
    int q_tag [DEPTH];
    int q_addr [DEPTH];
    int qn = 0;
    bit out_v [SC_N];
    int out_tag [SC_N];
    int out_op [SC_N];
    int out_cyc [SC_N];
    int rr_exp = 0;
    int last_poll = 0;
    int cyc = 0;
    int n_acc = 0;
    int n_done = 0;
    bit saw_full = 1'b0;
    int iss_log [3];
    int iss_n = 0;
    int done_log [3];
    int done_n = 0;
    bit log_on = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    function automatic int lat_of(input int op);
        if (op == 1) return L_PG;
        if (op == 2) return L_ER;
        return L_RD;
    endfunction

    function automatic int first_eligible();
        for (int i = 0; i < qn; i++)
            if (!out_v[q_sc[i]]) return i;
        return -1;
    endfunction

    function automatic int rr_expect();
        for (int k = 0; k < SC_N; k++)
            if (out_v[(rr_exp + k) % SC_N]) return (rr_exp + k) % SC_N;
        return -1;
    endfunction

    // monitor: samples at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            chk(cmd_ready == (qn < DEPTH), "R2 ready vs pending count", int'(cmd_ready), int'(qn < DEPTH));
            if (qn == DEPTH) saw_full = 1'b1;
            chk(int'(fl_issue_valid) + int'(fl_poll_valid) + int'(done_valid) <= 1,
                "R9 single action per cycle", int'(fl_issue_valid) + int'(fl_poll_valid) + int'(done_valid), 1);
            if (fl_issue_valid) begin
                automatic int e = first_eligible();
                if (e < 0) begin
                    chk(1'b0, "R5 issue with no free target", int'(fl_issue_sc), -1);
                end else begin
                    chk(int'(fl_issue_tag) == q_tag[e], "R3 issued tag", int'(fl_issue_tag), q_tag[e]);
                    chk(int'(fl_issue_sc) == q_sc[e] && int'(fl_issue_op) == q_op[e] &&
                        int'(fl_issue_addr) == q_addr[e], "R3 issued fields",
                        int'(fl_issue_addr), q_addr[e]);
                    chk(!out_v[fl_issue_sc], "R5 target idle", int'(out_v[fl_issue_sc]), 0);
                    if (log_on && iss_n < 3) begin iss_log[iss_n] = int'(fl_issue_tag); iss_n++; end
                    out_v[fl_issue_sc]   = 1'b1;
                    out_tag[fl_issue_sc] = int'(fl_issue_tag);
                    out_op[fl_issue_sc]  = int'(fl_issue_op);
                    out_cyc[fl_issue_sc] = cyc;
                    for (int i = e; i < qn - 1; i++) begin
                        q_op[i] = q_op[i+1]; q_sc[i] = q_sc[i+1];
                        q_tag[i] = q_tag[i+1]; q_addr[i] = q_addr[i+1];
                    end
                    qn--;
                end
            end
            if (fl_poll_valid) begin
                chk(first_eligible() < 0, "R9 poll while issue possible", first_eligible(), -1);
                chk(int'(fl_poll_sc) == rr_expect(), "R6 round-robin poll target", int'(fl_poll_sc), rr_expect());
                last_poll = int'(fl_poll_sc);
                rr_exp = (int'(fl_poll_sc) + 1) % SC_N;
            end
            if (done_valid) begin
                chk(out_v[done_sc], "R8 completion for outstanding op", 0, 1);
                chk(int'(done_sc) == last_poll, "R7 completion follows poll", int'(done_sc), last_poll);
                chk(int'(done_tag) == out_tag[done_sc], "R7 completion tag", int'(done_tag), out_tag[done_sc]);
                chk(cyc - out_cyc[done_sc] >= lat_of(out_op[done_sc]) + 1, "R7 completion not before latency",
                    cyc - out_cyc[done_sc], lat_of(out_op[done_sc]) + 1);
                if (log_on && done_n < 3) begin done_log[done_n] = int'(done_tag); done_n++; end
                out_v[done_sc] = 1'b0;
                n_done++;
            end
            if (cmd_valid && cmd_ready) begin
                q_op[qn] = int'(cmd_op); q_sc[qn] = int'(cmd_sc);
                q_tag[qn] = int'(cmd_tag); q_addr[qn] = int'(cmd_addr);
                qn++;
                n_acc++;
            end
        end
    end

    // called at posedge + 1
    task automatic send(input int op, input int sc, input int tag, input int addr);
        automatic bit acc = 1'b0;
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_sc    = 2'(sc);
        cmd_tag   = TAG_W'(tag);
        cmd_addr  = ADDR_W'(addr);
        while (!acc) begin
            #3;
            acc = cmd_ready;
            @(posedge clk); #1;
        end
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        automatic int guard = 0;
        while ((n_done != n_acc || qn != 0) && guard < 5000) begin
            @(posedge clk); #1;
            guard++;
        end
    endtask

    initial begin
        automatic int tag = 0;
        automatic int seed = 32'h5eed_0c4a;
        void'($urandom(seed));
        for (int s = 0; s < SC_N; s++) out_v[s] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!fl_issue_valid && !fl_poll_valid && !done_valid, "R1 quiet in reset",
            int'(fl_issue_valid) + int'(fl_poll_valid) + int'(done_valid), 0);
        chk(cmd_ready, "R1 ready in reset", int'(cmd_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fl_issue_valid && !fl_poll_valid && !done_valid, "R1 quiet after reset",
            int'(fl_issue_valid) + int'(fl_poll_valid) + int'(done_valid), 0);
        @(posedge clk); #1;

        // directed: erase sc0, read sc0, read sc1 -> read sc1 overtakes (R3, R4)
        log_on = 1'b1;
        send(2, 0, 1, 100);
        send(0, 0, 2, 101);
        send(0, 1, 3, 102);
        drain();
        log_on = 1'b0;
        chk(iss_n == 3 && iss_log[0] == 1, "R3 first issue erase", iss_log[0], 1);
        chk(iss_log[1] == 3, "R3 read to free chip overtakes", iss_log[1], 3);
        chk(iss_log[2] == 2, "R4 same-chip read after erase", iss_log[2], 2);
        chk(done_n == 3 && done_log[0] == 3, "R3 overtaking read completes first", done_log[0], 3);
        chk(done_log[1] == 1 && done_log[2] == 2, "R4 same-chip completion order", done_log[2], 2);
        tag = 4;

        // directed: flood one super chip to fill the window (R2)
        for (int i = 0; i < DEPTH + 3; i++) begin
            send(1, 2, tag, 200 + i);
            tag = (tag + 1) % 256;
        end
        chk(saw_full, "R2 window reached full", int'(saw_full), 1);
        drain();

        // random traffic
        for (int i = 0; i < 500; i++) begin
            automatic int gap = int'($urandom % 3);
            repeat (gap) begin @(posedge clk); #1; end
            send(int'($urandom % 3), int'($urandom % SC_N), tag, int'($urandom % (1 << ADDR_W)));
            tag = (tag + 1) % 256;
        end
        drain();
        chk(n_done == n_acc, "R8 all accepted commands completed", n_done, n_acc);
        chk(qn == 0 && cmd_ready, "R2 window empty at end", qn, 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_done, n_acc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule